// File: doc/BRIEF.md
# Trap Vector and Exception PC Unit

This unit holds the three registers a core consults when it enters a trap handler: the trap-vector register, the trap-cause register and the exception program counter. Software writes them through a simple CSR write port. The unit computes the handler entry address from the current trap-vector and cause values and presents it with a valid flag. The surrounding core decides whether a trap is taken and switches privilege.

When the core takes a trap, it pulses a strobe with the interrupt flag, the cause code and the faulting PC. In the same clock edge the unit loads the cause register and a legalized copy of the PC. Writes and reads of the exception PC follow an alignment rule that depends on whether compressed instructions are enabled. Entry addresses are either a single fixed location or, for interrupts only, a table indexed by the cause code.

Top module: `trap_vec_unit`

## Requirements
- R1: After synchronous reset, the trap-vector, cause and exception PC values read zero, `handler_addr` is zero and `handler_valid` is high.
- R2: A CSR write with `csr_wr_sel` = 2'b00 whose data carries a mode of 2'b00 (direct) or 2'b01 (vectored) in bits [1:0] stores the whole written word in the trap-vector register, visible on `tvec_value` after the next edge. Select 2'b01 is the cause register, 2'b10 is the exception PC, and 2'b11 writes nothing.
- R3: A trap-vector write whose mode bits are 2'b10 or 2'b11 stores the new base in bits [XLEN-1:2] and keeps the previous mode bits.
- R4: In direct mode, `handler_addr` equals the base with two zero bits below it, whatever the cause.
- R5: In vectored mode with the cause's top bit (interrupt flag) set, `handler_addr` equals the base plus four times the cause code in bits [XLEN-2:0], modulo 2^XLEN.
- R6: In vectored mode with the interrupt flag clear, `handler_addr` equals the base.
- R7: A CSR write to the cause register stores the whole written word.
- R8: When `c_enable` is high or the parameter `C_WRITABLE` is set, a write to the exception PC clears only bit 0 of the stored value.
- R9: When `c_enable` is low and `C_WRITABLE` is clear, a write to the exception PC clears bits [1:0] of the stored value.
- R10: `epc_rd` shows the stored exception PC with bit 1 forced to zero while `c_enable` is low. While `c_enable` is high it shows the stored value unchanged.
- R11: On a cycle with `trap_take` high, the cause register loads {`trap_is_irq`, `trap_code`} and the exception PC loads `trap_pc` legalized as in R8/R9. Both take effect at the same edge and override a CSR write to either register in that cycle.
- R12: `handler_valid` is high exactly when the stored mode is direct or vectored. Because of R3, it stays high after any sequence of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_wr_sel | input | 2 | Target register: 00 vector, 01 cause, 10 exception PC, 11 none |
| csr_wr_data | input | XLEN | CSR write data |
| trap_take | input | 1 | Trap-entry strobe |
| trap_is_irq | input | 1 | Trap is an interrupt |
| trap_code | input | XLEN-1 | Trap cause code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| c_enable | input | 1 | Compressed instructions currently enabled |
| tvec_value | output | XLEN | Trap-vector register contents |
| cause_value | output | XLEN | Cause register contents |
| epc_rd | output | XLEN | Exception PC as seen by a read |
| handler_addr | output | XLEN | Computed handler entry address |
| handler_valid | output | 1 | Handler address is meaningful |

## Verification
The bench writes a sequence of vector and cause values. The sequence moves between direct and vectored modes, sends reserved mode codes while each mode is active, and adds an interrupt code to a base near the top of the address space so the sum wraps. A design that dropped the base on a reserved write, or took the reserved code as the new mode, would produce wrong entry addresses. So would a design that vectored exceptions as well as interrupts. The exception PC is written and read under both settings of the compressed-instruction flag, to catch a mask that clears the wrong bits. Trap strobes are issued in the same cycle as competing CSR writes, to show that trap capture wins and that both registers update at the same edge.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;

    typedef enum logic [1:0] {
        TV_DIRECT   = 2'b00,
        TV_VECTORED = 2'b01,
        TV_RSVD_A   = 2'b10,
        TV_RSVD_B   = 2'b11
    } tv_mode_e;

    typedef enum logic [1:0] {
        SEL_TVEC  = 2'b00,
        SEL_CAUSE = 2'b01,
        SEL_EPC   = 2'b10,
        SEL_NONE  = 2'b11
    } csr_sel_e;

    typedef struct packed {
        logic tvec;
        logic cause;
        logic epc;
    } wr_strobe_t;

    function automatic logic mode_is_legal(input logic [1:0] m);
        return (m == TV_DIRECT) || (m == TV_VECTORED);
    endfunction

    function automatic wr_strobe_t decode_sel(input logic en, input csr_sel_e sel);
        wr_strobe_t s;
        s.tvec  = en && (sel == SEL_TVEC);
        s.cause = en && (sel == SEL_CAUSE);
        s.epc   = en && (sel == SEL_EPC);
        return s;
    endfunction

endpackage

// File: rtl/tv_vector_reg.sv
module tv_vector_reg
    import trapvec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] tvec_q
);
    logic [1:0] next_mode;

    always_comb begin
        next_mode = mode_is_legal(wr_data[1:0]) ? wr_data[1:0] : tvec_q[1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tvec_q <= '0;
        end else if (wr_en) begin
            tvec_q <= {wr_data[XLEN-1:2], next_mode};
        end
    end

    a_r2_legal_write_stored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode_is_legal(wr_data[1:0])) |=> (tvec_q == $past(wr_data)));

    a_r3_reserved_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mode_is_legal(wr_data[1:0])) |=>
            (tvec_q[1:0] == $past(tvec_q[1:0])) && (tvec_q[XLEN-1:2] == $past(wr_data[XLEN-1:2])));

    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(tvec_q));

endmodule

// File: rtl/tv_cause_epc.sv
module tv_cause_epc
    import trapvec_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit C_WRITABLE = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cause_wr,
    input  logic            epc_wr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            trap_take,
    input  logic            trap_is_irq,
    input  logic [XLEN-2:0] trap_code,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            c_enable,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] epc_q
);
    localparam logic [XLEN-1:0] HALF_MASK = ~{{(XLEN-1){1'b0}}, 1'b1};
    localparam logic [XLEN-1:0] WORD_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};

    logic            keep_bit1;
    logic [XLEN-1:0] epc_src;
    logic [XLEN-1:0] epc_legal;

    always_comb begin
        keep_bit1 = C_WRITABLE || c_enable;
        epc_src   = trap_take ? trap_pc : wr_data;
        epc_legal = epc_src & (keep_bit1 ? HALF_MASK : WORD_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (trap_take) begin
            cause_q <= {trap_is_irq, trap_code};
            epc_q   <= epc_legal;
        end else begin
            if (cause_wr) cause_q <= wr_data;
            if (epc_wr)   epc_q   <= epc_legal;
        end
    end

    a_r11_trap_cause: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> (cause_q == {$past(trap_is_irq), $past(trap_code)}));

    a_r11_trap_pc_upper: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> (epc_q[XLEN-1:2] == $past(trap_pc[XLEN-1:2])));

    a_r7_cause_write: assert property (@(posedge clk) disable iff (rst)
        (cause_wr && !trap_take) |=> (cause_q == $past(wr_data)));

    a_r8_epc_even: assert property (@(posedge clk) disable iff (rst)
        epc_q[0] == 1'b0);

    a_r9_epc_word_aligned: assert property (@(posedge clk) disable iff (rst)
        (epc_wr && !trap_take && !c_enable && !C_WRITABLE) |=> (epc_q[1:0] == 2'b00));

endmodule

// File: rtl/tv_target.sv
module tv_target
    import trapvec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] tvec_q,
    input  logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] target,
    output logic            target_valid
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic            is_irq;
    tv_mode_e        mode;

    always_comb begin
        mode   = tv_mode_e'(tvec_q[1:0]);
        base   = {tvec_q[XLEN-1:2], 2'b00};
        is_irq = cause_q[XLEN-1];
        offset = {cause_q[XLEN-3:0], 2'b00};
        target_valid = 1'b1;
        unique case (mode)
            TV_DIRECT:   target = base;
            TV_VECTORED: target = is_irq ? (base + offset) : base;
            default: begin
                target       = '0;
                target_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tv_epc_view.sv
module tv_epc_view #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] epc_q,
    input  logic            c_enable,
    output logic [XLEN-1:0] epc_rd
);
    always_comb begin
        epc_rd    = epc_q;
        epc_rd[1] = epc_q[1] & c_enable;
    end

endmodule

// File: rtl/trap_vec_unit.sv
module trap_vec_unit
    import trapvec_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit C_WRITABLE = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_wr_en,
    input  logic [1:0]      csr_wr_sel,
    input  logic [XLEN-1:0] csr_wr_data,
    input  logic            trap_take,
    input  logic            trap_is_irq,
    input  logic [XLEN-2:0] trap_code,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            c_enable,
    output logic [XLEN-1:0] tvec_value,
    output logic [XLEN-1:0] cause_value,
    output logic [XLEN-1:0] epc_rd,
    output logic [XLEN-1:0] handler_addr,
    output logic            handler_valid
);
    wr_strobe_t      strobe;
    logic [XLEN-1:0] tvec_q;
    logic [XLEN-1:0] cause_q;
    logic [XLEN-1:0] epc_q;

    always_comb begin
        strobe = decode_sel(csr_wr_en, csr_sel_e'(csr_wr_sel));
    end

    tv_vector_reg #(.XLEN(XLEN)) u_vec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (strobe.tvec),
        .wr_data (csr_wr_data),
        .tvec_q  (tvec_q)
    );

    tv_cause_epc #(.XLEN(XLEN), .C_WRITABLE(C_WRITABLE)) u_ce (
        .clk         (clk),
        .rst         (rst),
        .cause_wr    (strobe.cause),
        .epc_wr      (strobe.epc),
        .wr_data     (csr_wr_data),
        .trap_take   (trap_take),
        .trap_is_irq (trap_is_irq),
        .trap_code   (trap_code),
        .trap_pc     (trap_pc),
        .c_enable    (c_enable),
        .cause_q     (cause_q),
        .epc_q       (epc_q)
    );

    tv_target #(.XLEN(XLEN)) u_tgt (
        .tvec_q       (tvec_q),
        .cause_q      (cause_q),
        .target       (handler_addr),
        .target_valid (handler_valid)
    );

    tv_epc_view #(.XLEN(XLEN)) u_view (
        .epc_q    (epc_q),
        .c_enable (c_enable),
        .epc_rd   (epc_rd)
    );

    assign tvec_value  = tvec_q;
    assign cause_value = cause_q;

    a_r12_always_valid: assert property (@(posedge clk) disable iff (rst)
        handler_valid);

    a_r4_direct_target: assert property (@(posedge clk) disable iff (rst)
        (tvec_q[1:0] == TV_DIRECT) |-> (handler_addr == {tvec_q[XLEN-1:2], 2'b00}));

    a_r6_exception_to_base: assert property (@(posedge clk) disable iff (rst)
        ((tvec_q[1:0] == TV_VECTORED) && !cause_q[XLEN-1]) |->
            (handler_addr == {tvec_q[XLEN-1:2], 2'b00}));

    a_r5_irq_word_aligned: assert property (@(posedge clk) disable iff (rst)
        (tvec_q[1:0] == TV_VECTORED) |-> (handler_addr[1:0] == 2'b00));

    a_r10_read_mask: assert property (@(posedge clk) disable iff (rst)
        !c_enable |-> (epc_rd[1] == 1'b0));

endmodule

// File: tb/test_trap_vec_unit.sv
`timescale 1ns/1ps
module test_trap_vec_unit;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            csr_wr_en = 1'b0;
    logic [1:0]      csr_wr_sel = 2'b11;
    logic [XLEN-1:0] csr_wr_data = '0;
    logic            trap_take = 1'b0;
    logic            trap_is_irq = 1'b0;
    logic [XLEN-2:0] trap_code = '0;
    logic [XLEN-1:0] trap_pc = '0;
    logic            c_enable = 1'b1;
    logic [XLEN-1:0] tvec_value, cause_value, epc_rd, handler_addr;
    logic            handler_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    trap_vec_unit #(.XLEN(XLEN), .C_WRITABLE(1'b0)) i_trap_vec_unit (
        .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_wr_sel(csr_wr_sel),
        .csr_wr_data(csr_wr_data), .trap_take(trap_take), .trap_is_irq(trap_is_irq),
        .trap_code(trap_code), .trap_pc(trap_pc), .c_enable(c_enable),
        .tvec_value(tvec_value), .cause_value(cause_value), .epc_rd(epc_rd),
        .handler_addr(handler_addr), .handler_valid(handler_valid)
    );

    // columns: vector write, cause write, expected vector, expected handler
    localparam logic [31:0] VEC [0:8][0:3] = '{
        '{32'h0000_1000, 32'h8000_0003, 32'h0000_1000, 32'h0000_1000},
        '{32'h0000_1001, 32'h8000_0003, 32'h0000_1001, 32'h0000_100C},
        '{32'h0000_1001, 32'h0000_0005, 32'h0000_1001, 32'h0000_1000},
        '{32'h8000_0101, 32'h8000_0007, 32'h8000_0101, 32'h8000_011C},
        '{32'hFFFF_FFFD, 32'h8000_0002, 32'hFFFF_FFFD, 32'h0000_0004},
        '{32'h0000_2003, 32'h8000_0001, 32'h0000_2001, 32'h0000_2004},
        '{32'h0000_3002, 32'h0000_000B, 32'h0000_3001, 32'h0000_3000},
        '{32'h0000_4000, 32'h8000_000B, 32'h0000_4000, 32'h0000_4000},
        '{32'h0000_5006, 32'h8000_0003, 32'h0000_5004, 32'h0000_5004}
    };

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [1:0] sel, input logic [XLEN-1:0] data);
        csr_wr_en   = 1'b1;
        csr_wr_sel  = sel;
        csr_wr_data = data;
        @(negedge clk);
        csr_wr_en   = 1'b0;
        csr_wr_sel  = 2'b11;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 tvec", tvec_value, '0);
        check("R1 cause", cause_value, '0);
        check("R1 epc", epc_rd, '0);
        check("R1 handler", handler_addr, '0);
        check("R1 valid", {31'b0, handler_valid}, 32'd1);

        // table walk: R2 R3 R4 R5 R6 R7 R12
        for (int i = 0; i < 9; i++) begin
            csr_wr(2'b00, VEC[i][0]);
            csr_wr(2'b01, VEC[i][1]);
            check($sformatf("R2/R3 vector row %0d", i), tvec_value, VEC[i][2]);
            check($sformatf("R7 cause row %0d", i), cause_value, VEC[i][1]);
            check($sformatf("R4/R5/R6 handler row %0d", i), handler_addr, VEC[i][3]);
            check($sformatf("R12 valid row %0d", i), {31'b0, handler_valid}, 32'd1);
        end

        // select 11 writes nothing
        csr_wr(2'b11, 32'hDEAD_BEEF);
        check("R2 none select vector", tvec_value, 32'h0000_5004);
        check("R2 none select cause", cause_value, 32'h8000_0003);

        // R8: compressed enabled clears bit 0 only
        c_enable = 1'b1;
        csr_wr(2'b10, 32'h0000_1237);
        check("R8 epc half aligned", epc_rd, 32'h0000_1236);
        // R10: read masks bit 1 when compressed disabled
        c_enable = 1'b0;
        #1;
        check("R10 read mask", epc_rd, 32'h0000_1234);
        c_enable = 1'b1;
        #1;
        check("R10 read unmasked", epc_rd, 32'h0000_1236);
        // R9: compressed disabled clears bits [1:0]
        c_enable = 1'b0;
        csr_wr(2'b10, 32'h0000_567F);
        c_enable = 1'b1;
        #1;
        check("R9 epc word aligned", epc_rd, 32'h0000_567C);

        // R11: trap overrides competing cause write
        csr_wr(2'b00, 32'h0000_0101);
        c_enable    = 1'b1;
        trap_take   = 1'b1;
        trap_is_irq = 1'b1;
        trap_code   = 31'd6;
        trap_pc     = 32'h0000_2003;
        csr_wr(2'b01, 32'h0000_0005);
        trap_take   = 1'b0;
        check("R11 trap cause", cause_value, 32'h8000_0006);
        check("R11 trap epc", epc_rd, 32'h0000_2002);
        check("R5 trap handler", handler_addr, 32'h0000_0118);

        // R11: trap overrides competing epc write, word-aligned capture
        c_enable    = 1'b0;
        trap_take   = 1'b1;
        trap_is_irq = 1'b0;
        trap_code   = 31'd2;
        trap_pc     = 32'h0000_3007;
        csr_wr(2'b10, 32'h0000_9999);
        trap_take   = 1'b0;
        c_enable    = 1'b1;
        #1;
        check("R11 exc cause", cause_value, 32'h0000_0002);
        check("R11 exc epc", epc_rd, 32'h0000_3004);
        check("R6 exc handler", handler_addr, 32'h0000_0100);

        // R1 reset again clears state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 re-reset tvec", tvec_value, '0);
        check("R1 re-reset epc", epc_rd, '0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule